// File: doc/BRIEF.md
# Pipelined Cascadable Parity Checker

This block checks a word of data bits against a parity bit that arrives one clock after that word. The word is captured on the first edge, and its parity bit on the next edge. One edge after that, the verdict lands in an error register that drives an active-low, open-drain flag. The block has one data path, so it works the same whether the surrounding bus logic registers the data or passes it straight through.

A lone checker uses its bidirectional parity pin as a static selector: low selects even parity and high selects odd parity. Two checkers can cover a wider word. The first one has its parity output enabled, and it drives the XOR of its own data bits onto the shared pin. This output is registered so that it lines up with the delayed parity bit. The second checker has its parity output disabled. It folds that partial sum into its own check, so its error flag covers both halves. A separate data line doubles as an active-low enable for the error register. A general active-low output enable releases the flag.

Top module: `casc_parity_chk`

## Requirements
- R1: While reset is active and after reset, the error flag is released (reads high through a pull-up) until the error register is first loaded with a mismatch.
- R2: With the parity pin as an input held low, a load sets the error when the count of ones in the data word plus the delayed parity bit is odd.
- R3: With the parity pin as an input held high, a load sets the error when the count of ones in the data word plus the delayed parity bit is even.
- R4: The parity bit is sampled one edge after its data word. The error verdict for that word becomes visible on the flag right after the following edge, which is the second edge after the data.
- R5: The error register loads only on an edge where the error-enable line is low. On an edge where it is high, the register keeps its value.
- R6: The flag is open drain: it is pulled to 0 while an error is held and outputs are enabled, and it is never driven to 1.
- R7: While the active-low output enable is high, the flag is released whatever the error register holds.
- R8: With the parity output enable low, the parity pin's output enable is high, and the pin carries the XOR of the data word sampled two edges earlier. This value is valid after the edge that follows the data.
- R9: With the parity output enable high, the pin's output enable is low, and the value on the pin is XORed into the check in place of the even/odd selector.
- R10: While it drives its partial sum (parity output enable low), the block checks its own word for even parity, ignoring the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_i | input | DW (10) | Data word under check |
| par_i | input | 1 | Parity bit for the word of the previous cycle |
| err_en_n | input | 1 | Active-low error register load enable (a data line reused) |
| pout_en_n | input | 1 | Active-low enable for driving the partial sum onto the parity pin |
| pio_i | input | 1 | Parity pin input: even/odd selector or partner's partial sum |
| pio_o | output | 1 | Parity pin output: registered partial sum of the data word |
| pio_oe | output | 1 | Parity pin output enable |
| oe_n | input | 1 | Active-low output enable for the error flag |
| err_n | output | 1 | Open-drain error flag, driven 0 or high impedance |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that the value on the parity pin is valid at the edge where the error register loads. Checks that look back to the data word hold off until three edges have passed since reset, so that no pre-reset history is used.

The stimulus drives every input on the falling edge. Within each run of stimulus, the parity mode and the pin source stay fixed. The load enable is held high for the first two cycles of each run, so that words left in the pipeline from the previous mode are never loaded.

// File: rtl/casc_parity_pkg.sv
package casc_parity_pkg;
  // Data captured on the second pipeline edge: partial sum and parity bit
  typedef struct packed {
    logic sum;
    logic par;
  } cpc_stage_t;
endpackage

// File: rtl/cpc_rst_sync.sv
module cpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/cpc_front.sv
module cpc_front
  import casc_parity_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dat_i,
  input  logic          par_i,
  output cpc_stage_t    stg_o
);
  logic [DW-1:0] dat_q;
  logic [DW-1:0] dat_d;
  logic [DW:0]   chain;
  cpc_stage_t    stg_q;
  cpc_stage_t    stg_d;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < DW; g++) begin : g_xor
    assign chain[g+1] = chain[g] ^ dat_q[g];
  end

  always_comb begin
    dat_d     = dat_i;
    stg_d.sum = chain[DW];
    stg_d.par = par_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      stg_q <= '0;
    end else begin
      dat_q <= dat_d;
      stg_q <= stg_d;
    end
  end

  assign stg_o = stg_q;
endmodule

// File: rtl/cpc_errreg.sv
module cpc_errreg
  import casc_parity_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cpc_stage_t stg_i,
  input  logic       mix_i,
  input  logic       load_n,
  output logic       err_o
);
  logic err_q;
  logic err_d;

  always_comb begin
    if (!load_n) err_d = stg_i.sum ^ stg_i.par ^ mix_i;
    else         err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/cpc_pads.sv
module cpc_pads (
  input  logic err_i,
  input  logic oe_n,
  input  logic sum_i,
  input  logic pout_en_n,
  output logic pio_o,
  output logic pio_oe,
  output wire  err_n
);
  logic pull;

  assign pull   = err_i & ~oe_n;
  assign pio_o  = sum_i;
  assign pio_oe = ~pout_en_n;
  assign err_n  = pull ? 1'b0 : 1'bz;
endmodule

// File: rtl/casc_parity_chk.sv
module casc_parity_chk
  import casc_parity_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dat_i,
  input  logic          par_i,
  input  logic          err_en_n,
  input  logic          pout_en_n,
  input  logic          pio_i,
  output logic          pio_o,
  output logic          pio_oe,
  input  logic          oe_n,
  output wire           err_n
);
  logic       rst_s_n;
  cpc_stage_t stg;
  logic       mix;
  logic       err_q;

  cpc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  cpc_front #(.DW(DW)) u_front (
    .clk(clk), .rst_n(rst_s_n), .dat_i(dat_i), .par_i(par_i), .stg_o(stg)
  );

  // The pin feeds the check only when it is an input
  assign mix = pout_en_n ? pio_i : 1'b0;

  cpc_errreg u_err (
    .clk(clk), .rst_n(rst_s_n), .stg_i(stg), .mix_i(mix),
    .load_n(err_en_n), .err_o(err_q)
  );

  cpc_pads u_pads (
    .err_i(err_q), .oe_n(oe_n), .sum_i(stg.sum), .pout_en_n(pout_en_n),
    .pio_o(pio_o), .pio_oe(pio_oe), .err_n(err_n)
  );

  // Edges seen since reset release, saturating; gates look-back checks
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_LOAD_INPUT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (age_q >= 2'd2 && !err_en_n && pout_en_n) |=>
      err_q == (^$past(dat_i, 3) ^ $past(par_i, 2) ^ $past(pio_i))); // R2
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (age_q >= 2'd2 && !err_en_n && !pout_en_n) |=>
      err_q == (^$past(dat_i, 3) ^ $past(par_i, 2))); // R10
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_en_n |=> $stable(err_q)); // R5
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(err_q) |-> $past(!err_en_n)); // R5
  AST_SUM_OUT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (age_q >= 2'd1) |=> pio_o == ^$past(dat_i, 2)); // R8
endmodule

// File: tb/casc_parity_chk_test.sv
`timescale 1ns/1ps
module casc_parity_chk_test;
  localparam int DW = 10;

  typedef struct {
    logic  line;
    logic  chk_pio;
    logic  pio;
    logic  pio_oe;
    string req;
  } item_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] dat_a, dat_b;
  logic          par_a, en_a, pout_a, oe_a;
  logic [1:0]    pio_src;
  logic          pio_a_i, pio_a_o, pio_a_oe;
  logic          pio_b_o, pio_b_oe;
  wire           err_line;
  wire           err_peer;
  pullup (err_line);
  pullup (err_peer);

  int checks = 0;
  int errors = 0;
  item_t q[$];

  // pio_src: 0 even select, 1 odd select, 2 partner sum, 3 own loopback
  assign pio_a_i = (pio_src == 2'd0) ? 1'b0 :
                   (pio_src == 2'd1) ? 1'b1 :
                   (pio_src == 2'd2) ? pio_b_o : pio_a_o;

  casc_parity_chk #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .dat_i(dat_a), .par_i(par_a), .err_en_n(en_a),
    .pout_en_n(pout_a), .pio_i(pio_a_i), .pio_o(pio_a_o), .pio_oe(pio_a_oe),
    .oe_n(oe_a), .err_n(err_line)
  );

  casc_parity_chk #(.DW(DW)) peer (
    .clk(clk), .rst_n(rst_n), .dat_i(dat_b), .par_i(1'b0), .err_en_n(1'b1),
    .pout_en_n(1'b0), .pio_i(1'b0), .pio_o(pio_b_o), .pio_oe(pio_b_oe),
    .oe_n(1'b1), .err_n(err_peer)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  // Monitor: compares the state after each edge with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(err_line, it.line, {it.req, " error flag"});
        if (it.chk_pio) check(pio_a_o, it.pio, "R8 partial sum on pin");
        check(pio_a_oe, it.pio_oe, "R8 R9 pin output enable");
      end
    end
  end

  logic exp_err;

  // Driver: one stream of words in a fixed mode, pushing one item per edge
  task automatic run_phase(input int ph, input int ncyc);
    logic [DW-1:0] wa[64];
    logic [DW-1:0] wb[64];
    logic          pa[64];
    logic          ea[64];
    string         tag;
    tag = (ph == 0) ? "R2" : (ph == 1) ? "R3" : (ph == 2) ? "R9" : "R10";
    for (int n = 0; n < ncyc; n++) begin
      item_t it;
      logic  mix;
      @(negedge clk);
      wa[n] = DW'($urandom);
      wb[n] = DW'($urandom);
      pa[n] = 1'($urandom);
      ea[n] = ($urandom % 3) == 0;
      pio_src = 2'(ph);
      pout_a  = (ph == 3) ? 1'b0 : 1'b1;
      dat_a   = wa[n];
      dat_b   = wb[n];
      par_a   = (n >= 1) ? pa[n-1] : 1'b0;
      en_a    = (n >= 2) ? ea[n-2] : 1'b1;
      oe_a    = ($urandom % 4) == 0;
      if (n >= 2 && !ea[n-2]) begin
        mix = (ph == 1) ? 1'b1 : (ph == 2) ? ^wb[n-2] : 1'b0;
        exp_err = (^wa[n-2]) ^ pa[n-2] ^ mix;
      end
      it.line    = (exp_err && !oe_a) ? 1'b0 : 1'b1;
      it.chk_pio = (n >= 1);
      it.pio     = (n >= 1) ? ^wa[n-1] : 1'b0;
      it.pio_oe  = (ph == 3);
      it.req     = {tag, oe_a ? " R7" : " R6", " R4 R5"};
      q.push_back(it);
    end
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0; dat_a = '0; dat_b = '0; par_a = 1'b0; en_a = 1'b1;
    pout_a = 1'b1; oe_a = 1'b0; pio_src = 2'd0; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    check(err_line, 1'b1, "R1 flag released in reset");
    check(pio_a_oe, 1'b0, "R1 R9 pin not driven in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(err_line, 1'b1, "R1 flag released after reset");
    run_phase(0, 40);
    run_phase(1, 40);
    run_phase(2, 40);
    run_phase(3, 40);
    @(negedge clk);
    en_a = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule